// File: doc/BRIEF.md
# Rate-Controlled Fault Injection Wrapper

This block sits in series with a data word and normally passes it straight through. On command it corrupts the word so that a design with online or offline self-test can be exercised against faults. There are two kinds of fault. A transient fault inverts one bit of the word for a single clock cycle, at an average rate set by a 4-bit code. A permanent fault holds either one selected bit or the whole word at a fixed value for as long as that mode is selected.

The transient rate comes from two free-running 16-bit maximal-length shift-register generators, each started from its own seed. In every cycle the wrapper compares their low bits. The rate code sets how many low bits take part, and a full match triggers an injection. The bit that gets inverted is chosen from the first generator, so successive events land on different bit positions across the word. A flag output is high in exactly the cycles where the output word differs from the input word.

Top module: `rate_fault_wrap`

## Requirements
- R1: Each generator steps once per clock after reset release, in right-shifting Galois form for x^16+x^14+x^13+x^11+1. The next state is (s >> 1) XOR (s[0] ? 16'hB400 : 0).
- R2: While the internal reset is active, generator A loads seed_a_i and generator B loads seed_b_i. An all-zero seed is replaced by 16'hACE1 for A and by 16'h5A3C for B, so neither generator is ever zero.
- R3: For rate code N in 1..15, an injection is decided at a clock edge when bits N-1..0 of the two generators, taken before that edge, are equal. The injection shows on the outputs during the cycle that follows that edge.
- R4: Rate code 0 never produces a transient fault.
- R5: A transient fault inverts exactly one bit. Its index comes from the low IDX_W bits of generator A, sampled at the deciding edge. If that value is DATA_W or more, DATA_W is subtracted from it.
- R6: With DATA_W=1, every transient fault inverts bit 0.
- R7: mode_i=2'b00 (pass) gives data_o equal to data_i and fault_o low in every cycle.
- R8: mode_i=2'b10 (stuck bit) forces bit stuck_sel_i to stuck_val_i and passes all other bits unchanged. stuck_sel_i is folded the same way as in R5, and the effect is combinational.
- R9: mode_i=2'b11 (stuck word) drives data_o equal to stuck_word_i. mode_i=2'b01 selects transient injection.
- R10: fault_o is high exactly when data_o differs from data_i.
- R11: rst_n is asserted asynchronously and released through two clock edges. Any pending transient decision is cleared during reset, so after reset no fault shows until a new match is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| data_i | input | DATA_W | Word to be passed or corrupted |
| rate_ctrl_i | input | 4 | Number of low generator bits compared; 0 disables transient faults |
| mode_i | input | 2 | 00 pass, 01 transient, 10 stuck bit, 11 stuck word |
| seed_a_i | input | 16 | Seed for generator A |
| seed_b_i | input | 16 | Seed for generator B |
| stuck_sel_i | input | IDX_W | Bit index for stuck-bit mode |
| stuck_val_i | input | 1 | Value forced in stuck-bit mode |
| stuck_word_i | input | DATA_W | Value forced in stuck-word mode |
| data_o | output | DATA_W | Possibly corrupted word |
| fault_o | output | 1 | High when data_o differs from data_i |

## Verification
The bench builds three copies of the wrapper with DATA_W set to 8, 5 and 1. All three share one stimulus and are checked against one reference model of the generators. The width of 8 covers the power-of-two path, where the index is taken directly from the low generator bits. The width of 5 covers the fold path, where index values 5 to 7 wrap to 0 to 2, for both the flip index and the stuck-bit select. The width of 1 shows that every transient event lands on the single bit, and that the select input has no effect there.

// File: rtl/fi_pkg.sv
`timescale 1ns/1ps
package fi_pkg;
  localparam int GEN_W  = 16;
  localparam int RATE_W = 4;
  localparam logic [GEN_W-1:0] GEN_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    FI_PASS       = 2'b00,
    FI_TRANSIENT  = 2'b01,
    FI_STUCK_BIT  = 2'b10,
    FI_STUCK_WORD = 2'b11
  } fi_mode_e;

  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
    return {1'b0, s[GEN_W-1:1]} ^ (s[0] ? GEN_TAPS : '0);
  endfunction
endpackage

// File: rtl/fi_rst_sync.sv
`timescale 1ns/1ps
module fi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fi_gen.sv
`timescale 1ns/1ps
module fi_gen import fi_pkg::*; #(
  parameter logic [GEN_W-1:0] ZERO_SUB = 16'hACE1
) (
  input  logic             clk,
  input  logic             load_i,
  input  logic [GEN_W-1:0] seed_i,
  output logic [GEN_W-1:0] state_o
);
  logic [GEN_W-1:0] state_q, state_d, seed_eff;

  always_comb begin
    seed_eff = (seed_i == '0) ? ZERO_SUB : seed_i;
    state_d  = load_i ? seed_eff : gen_step(state_q);
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fi_trigger.sv
`timescale 1ns/1ps
module fi_trigger import fi_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              clear_i,
  input  logic [GEN_W-1:0]  gen_a_i,
  input  logic [GEN_W-1:0]  gen_b_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  raw_idx_o
);
  logic [GEN_W-1:0] cmp_en;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  for (genvar g = 0; g < GEN_W; g++) begin : g_cmp_en
    assign cmp_en[g] = (rate_i > RATE_W'(g));
  end

  always_comb begin
    if (clear_i) begin
      hit_d = 1'b0;
      idx_d = '0;
    end else begin
      hit_d = (rate_i != '0) && (((gen_a_i ^ gen_b_i) & cmp_en) == '0);
      idx_d = gen_a_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    hit_q <= hit_d;
    idx_q <= idx_d;
  end

  assign hit_o     = hit_q;
  assign raw_idx_o = idx_q;
endmodule

// File: rtl/fi_idx_fold.sv
`timescale 1ns/1ps
module fi_idx_fold #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0] raw_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam bit IS_POW2 = ((DATA_W & (DATA_W - 1)) == 0);

  if (DATA_W == 1) begin : g_single
    assign idx_o = raw_i & '0;
  end else if (IS_POW2) begin : g_pow2
    assign idx_o = raw_i;
  end else begin : g_wrap
    localparam logic [IDX_W-1:0] WIDTH_L = IDX_W'(DATA_W);
    assign idx_o = (raw_i >= WIDTH_L) ? (raw_i - WIDTH_L) : raw_i;
  end
endmodule

// File: rtl/rate_fault_wrap.sv
`timescale 1ns/1ps
module rate_fault_wrap import fi_pkg::*; #(
  parameter int DATA_W = 8,
  parameter logic [GEN_W-1:0] ZERO_SUB_A = 16'hACE1,
  parameter logic [GEN_W-1:0] ZERO_SUB_B = 16'h5A3C,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic [RATE_W-1:0] rate_ctrl_i,
  input  logic [1:0]        mode_i,
  input  logic [GEN_W-1:0]  seed_a_i,
  input  logic [GEN_W-1:0]  seed_b_i,
  input  logic [IDX_W-1:0]  stuck_sel_i,
  input  logic              stuck_val_i,
  input  logic [DATA_W-1:0] stuck_word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fault_o
);
  logic             rst_sync_n;
  logic [GEN_W-1:0] gen_a_q, gen_b_q;
  logic             hit_q;
  logic [IDX_W-1:0] raw_idx_q, flip_idx, sel_idx;
  fi_mode_e         mode;

  fi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fi_gen #(.ZERO_SUB(ZERO_SUB_A)) u_gen_a (
    .clk(clk), .load_i(!rst_sync_n), .seed_i(seed_a_i), .state_o(gen_a_q)
  );

  fi_gen #(.ZERO_SUB(ZERO_SUB_B)) u_gen_b (
    .clk(clk), .load_i(!rst_sync_n), .seed_i(seed_b_i), .state_o(gen_b_q)
  );

  fi_trigger #(.IDX_W(IDX_W)) u_trig (
    .clk(clk), .clear_i(!rst_sync_n), .gen_a_i(gen_a_q), .gen_b_i(gen_b_q),
    .rate_i(rate_ctrl_i), .hit_o(hit_q), .raw_idx_o(raw_idx_q)
  );

  fi_idx_fold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fold_flip (
    .raw_i(raw_idx_q), .idx_o(flip_idx)
  );

  fi_idx_fold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fold_sel (
    .raw_i(stuck_sel_i), .idx_o(sel_idx)
  );

  assign mode = fi_mode_e'(mode_i);

  always_comb begin
    data_o  = data_i;
    fault_o = 1'b0;
    unique case (mode)
      FI_TRANSIENT: begin
        if (hit_q) begin
          data_o  = data_i ^ (DATA_W'(1) << flip_idx);
          fault_o = 1'b1;
        end
      end
      FI_STUCK_BIT: begin
        data_o[sel_idx] = stuck_val_i;
        fault_o         = (data_i[sel_idx] != stuck_val_i);
      end
      FI_STUCK_WORD: begin
        data_o  = stuck_word_i;
        fault_o = |(data_i ^ stuck_word_i);
      end
      default: begin
        data_o  = data_i;
        fault_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fi_checker.sv
`timescale 1ns/1ps
module fi_checker import fi_pkg::*; #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic [DATA_W-1:0] stuck_word_i,
  input logic [1:0]        mode_i,
  input logic [RATE_W-1:0] rate_ctrl_i,
  input logic              fault_o,
  input logic              hit_q,
  input logic [GEN_W-1:0]  gen_a_q,
  input logic [GEN_W-1:0]  gen_b_q
);
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b01) |-> ($countones(data_o ^ data_i) <= 1)); // R5
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o == (data_o != data_i)); // R10
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b00) |-> (data_o == data_i && !fault_o)); // R7
  AST_WORD_FORCED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == 2'b11) |-> (data_o == stuck_word_i)); // R9
  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rate_ctrl_i == 4'd0) |=> !hit_q); // R4
  AST_RATE_MISS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rate_ctrl_i == 4'd15 && gen_a_q[14:0] != gen_b_q[14:0]) |=> !hit_q); // R3
  AST_GEN_LIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gen_a_q != '0) && (gen_b_q != '0)); // R2
endmodule

bind rate_fault_wrap fi_checker #(.DATA_W(DATA_W)) u_fi_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .data_i(data_i), .data_o(data_o),
  .stuck_word_i(stuck_word_i), .mode_i(mode_i), .rate_ctrl_i(rate_ctrl_i),
  .fault_o(fault_o), .hit_q(hit_q), .gen_a_q(gen_a_q), .gen_b_q(gen_b_q)
);

// File: tb/rate_fault_wrap_tb_top.sv
`timescale 1ns/1ps
module rate_fault_wrap_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  d_data, d_word;
  logic [3:0]  d_rate;
  logic [1:0]  d_mode;
  logic [15:0] d_seed_a, d_seed_b;
  logic [2:0]  d_sel;
  logic        d_sval;

  logic [7:0] o8;  logic f8;
  logic [4:0] o5;  logic f5;
  logic [0:0] o1;  logic f1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  rate_fault_wrap #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .data_i(d_data), .rate_ctrl_i(d_rate),
    .mode_i(d_mode), .seed_a_i(d_seed_a), .seed_b_i(d_seed_b),
    .stuck_sel_i(d_sel), .stuck_val_i(d_sval), .stuck_word_i(d_word),
    .data_o(o8), .fault_o(f8)
  );

  rate_fault_wrap #(.DATA_W(5)) dut_w5_i (
    .clk(clk), .rst_n(rst_n), .data_i(d_data[4:0]), .rate_ctrl_i(d_rate),
    .mode_i(d_mode), .seed_a_i(d_seed_a), .seed_b_i(d_seed_b),
    .stuck_sel_i(d_sel), .stuck_val_i(d_sval), .stuck_word_i(d_word[4:0]),
    .data_o(o5), .fault_o(f5)
  );

  rate_fault_wrap #(.DATA_W(1)) dut_w1_i (
    .clk(clk), .rst_n(rst_n), .data_i(d_data[0:0]), .rate_ctrl_i(d_rate),
    .mode_i(d_mode), .seed_a_i(d_seed_a), .seed_b_i(d_seed_b),
    .stuck_sel_i(d_sel[0:0]), .stuck_val_i(d_sval), .stuck_word_i(d_word[0:0]),
    .data_o(o1), .fault_o(f1)
  );

  // Reference model built from R1, R2, R3, R11
  logic [1:0]  m_sync;
  logic [15:0] m_a, m_b;
  logic        m_hit;
  logic [2:0]  m_raw;

  function automatic logic [15:0] step(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always @(posedge clk) begin
    if (!m_sync[1]) begin
      m_a   <= (d_seed_a == 16'h0) ? 16'hACE1 : d_seed_a;
      m_b   <= (d_seed_b == 16'h0) ? 16'h5A3C : d_seed_b;
      m_hit <= 1'b0;
      m_raw <= 3'd0;
    end else begin
      m_a   <= step(m_a);
      m_b   <= step(m_b);
      m_hit <= (d_rate != 4'd0) &&
               (((m_a ^ m_b) & ((16'h1 << d_rate) - 16'h1)) == 16'h0);
      m_raw <= m_a[2:0];
    end
  end

  function automatic int fold(input int w, input logic [2:0] raw);
    if (w == 1) return 0;
    if (w == 5) return (raw >= 3'd5) ? int'(raw) - 5 : int'(raw);
    return int'(raw);
  endfunction

  function automatic logic [7:0] expect_out(input int w);
    logic [7:0] msk, din, r;
    msk = 8'((9'h1 << w) - 9'h1);
    din = d_data & msk;
    r = din;
    case (d_mode)
      2'b01: if (m_hit) r = din ^ (8'h1 << fold(w, m_raw));
      2'b10: r[fold(w, d_sel)] = d_sval;
      2'b11: r = d_word & msk;
      default: r = din;
    endcase
    return r & msk;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare all three copies against the model for this cycle
  task automatic check_now(input string req);
    logic [7:0] e8, e5, e1;
    e8 = expect_out(8);
    e5 = expect_out(5);
    e1 = expect_out(1);
    chk(o8 === e8, {req, " w8 data"}, 32'(o8), 32'(e8));
    chk(f8 === (e8 != d_data), {req, " R10 w8 flag"}, 32'(f8), 32'(e8 != d_data));
    chk(o5 === e5[4:0], {req, " w5 data"}, 32'(o5), 32'(e5));
    chk(f5 === (e5[4:0] != d_data[4:0]), {req, " R10 w5 flag"}, 32'(f5),
        32'(e5[4:0] != d_data[4:0]));
    chk(o1 === e1[0:0], {req, " R6 w1 data"}, 32'(o1), 32'(e1));
    chk(f1 === (e1[0] != d_data[0]), {req, " R10 w1 flag"}, 32'(f1),
        32'(e1[0] != d_data[0]));
  endtask

  task automatic run(input int n, input string req, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      d_data = 8'($urandom);
      #1;
      check_now(req);
      if (f8) hits++;
    end
  endtask

  task automatic do_reset(input logic [15:0] sa, input logic [15:0] sb);
    @(negedge clk);
    d_seed_a = sa;
    d_seed_b = sb;
    rst_n = 1'b0;
    d_mode = 2'b01;
    d_rate = 4'd1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      d_data = 8'($urandom);
      #1;
      chk(o8 === d_data && f8 === 1'b0, "R11 reset clean", 32'(o8), 32'(d_data));
      @(negedge clk);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_pass();
    int h;
    d_mode = 2'b00;
    d_rate = 4'd1;
    run(100, "R7 pass", h);
    chk(h == 0, "R7 no faults in pass", 32'(h), 32'd0);
  endtask

  task automatic t_transient(input logic [3:0] rate, input int n, input bit need_hits);
    int h;
    d_mode = 2'b01;
    d_rate = rate;
    run(n, "R1 R3 R5 transient", h);
    if (need_hits) chk(h > 0, "R3 injections seen", 32'(h), 32'd1);
  endtask

  task automatic t_rate_zero();
    int h;
    d_mode = 2'b01;
    d_rate = 4'd0;
    run(600, "R4 rate zero", h);
    chk(h == 0, "R4 no injections", 32'(h), 32'd0);
  endtask

  task automatic t_stuck_bit();
    int h;
    d_mode = 2'b10;
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 2; v++) begin
        d_sel  = 3'(s);
        d_sval = 1'(v);
        run(8, "R8 stuck bit", h);
      end
    end
  endtask

  task automatic t_stuck_word();
    int h;
    d_mode = 2'b11;
    d_word = 8'h00;  run(10, "R9 stuck word zeros", h);
    d_word = 8'hFF;  run(10, "R9 stuck word ones", h);
    d_word = 8'hA5;  run(10, "R9 stuck word pattern", h);
  endtask

  initial begin
    rst_n = 1'b0;
    d_data = 8'h00; d_word = 8'h00; d_rate = 4'd1; d_mode = 2'b01;
    d_seed_a = 16'h1234; d_seed_b = 16'hBEEF; d_sel = 3'd0; d_sval = 1'b0;
    do_reset(16'h1234, 16'hBEEF);
    t_pass();
    t_transient(4'd1, 300, 1'b1);
    t_transient(4'd4, 3000, 1'b1);
    t_transient(4'd15, 400, 1'b0);
    t_rate_zero();
    t_transient(4'd2, 500, 1'b1);
    t_stuck_bit();
    t_stuck_word();
    do_reset(16'h0000, 16'h0000);   // R2 zero-seed substitution
    t_transient(4'd3, 1500, 1'b1);
    do_reset(16'h0001, 16'h8000);
    t_transient(4'd2, 800, 1'b1);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=%0d exp=0", $time);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule